// File: doc/BRIEF.md
# Booth Multiplier Sequencing Controller

This block sequences a radix-2 Booth multiplier datapath. Each cycle it looks at the bit now sitting at the bottom of the multiplier register and issues one command: load the operands, add the multiplicand, subtract the multiplicand, or shift the accumulator and multiplier pair right by one place. The bit that was last shifted out is held as controller state, so the datapath needs no guard bit below the multiplier. Cycles that plain Booth recoding would spend on a no-op are spent on a shift instead.

The recoding is a two-state Mealy machine; one state means "the previous bit was 0" and the other means "the previous bit was 1". A load state and a finished state are added around it. The controller moves on every clock edge. After an add or a subtract the multiplier bit has not moved yet, so the very next command is always a shift. An external shift counter raises a completion flag once the operand width has been shifted. The controller then parks in its finished state until it is reset.

Reset is an asynchronous active-low input. Its release is synchronised inside the block.

Top module: `booth_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `op_code` is 2'b00 (load) and `finished` is 0. Both take these values at once, without waiting for a clock edge.
- R2: After reset is released, the load code 2'b00 is issued for at least one cycle and for at most SYNC_STAGES+1 cycles. It is then never issued again until the next reset. The first working state is the "previous bit 0" state.
- R3: In the "previous bit 0" state, with `count_hit` low and `mplr_lsb` at 0, the command is shift (2'b11) and the state does not change.
- R4: In the "previous bit 0" state, with `count_hit` low and `mplr_lsb` at 1, the command is subtract (2'b10) and the next state is "previous bit 1".
- R5: In the "previous bit 1" state, with `count_hit` low and `mplr_lsb` at 1, the command is shift (2'b11) and the state does not change.
- R6: In the "previous bit 1" state, with `count_hit` low and `mplr_lsb` at 0, the command is add (2'b01) and the next state is "previous bit 0".
- R7: After an add or a subtract, if `mplr_lsb` has not changed and `count_hit` is low, the next command is shift.
- R8: When `count_hit` is 1 in either working state, `count_hit` takes priority over `mplr_lsb`. The command in that cycle is the shift code, which the datapath ignores, and the next state is finished. When this sequencing drives a datapath, the result is the correct signed product.
- R9: Once finished, the block holds `finished` at 1 and `op_code` at 2'b11 whatever the inputs do, until reset.
- R10: `finished` is 0 in the load state and in both working states.
- R11: Pulling `rst_n` low in any state, including the finished state, returns the block to the load state. `op_code` becomes 2'b00 and `finished` becomes 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| mplr_lsb | input | 1 | Current least significant bit of the multiplier register |
| count_hit | input | 1 | High once the operand width has been shifted |
| op_code | output | 2 | 00 load, 01 add, 10 subtract, 11 shift |
| finished | output | 1 | High in the finished state |

## Verification
The bench drives a behavioural Booth datapath from the block's own commands and checks every command against an independent state model. If the add and subtract codes were swapped, or a transition pointed the wrong way, the signed product would be wrong. Directed cases include the most negative multiplicand and multiplier, all-ones operands and alternating bit patterns. Those operands make the recoding toggle on every bit, which exposes any missing forced shift after an arithmetic command. It also raises `count_hit` while an add is pending. A design that let the multiplier bit win over the completion flag would issue that add and corrupt the result. The bench also wiggles the inputs after the block has finished, and a design that left its finished state would show it. It pulls reset mid-run and in the finished state, and a design that waited for a clock edge would still show a working command or `finished` high.

// File: rtl/booth_ctrl_pkg.sv
`timescale 1ns/1ps
package booth_ctrl_pkg;

  localparam int STATE_W = 2;
  localparam int OP_W    = 2;

  // The two working states differ in one bit only.
  typedef enum logic [STATE_W-1:0] {
    ST_LOAD = 2'b00,
    ST_PB0  = 2'b01,
    ST_PB1  = 2'b11,
    ST_FIN  = 2'b10
  } ctrl_state_t;

  typedef enum logic [OP_W-1:0] {
    CMD_LOAD  = 2'b00,
    CMD_ADD   = 2'b01,
    CMD_SUB   = 2'b10,
    CMD_SHIFT = 2'b11
  } ctrl_cmd_t;

endpackage

// File: rtl/booth_rst_sync.sv
`timescale 1ns/1ps
module booth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
      assign srst_n = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/booth_step_logic.sv
`timescale 1ns/1ps
module booth_step_logic
  import booth_ctrl_pkg::*;
(
  input  ctrl_state_t cur,
  input  logic        lsb,
  input  logic        hit,
  output ctrl_state_t nxt,
  output ctrl_cmd_t   cmd
);
  always_comb begin
    nxt = cur;
    cmd = CMD_SHIFT;
    case (cur)
      ST_LOAD: begin
        cmd = CMD_LOAD;
        nxt = ST_PB0;
      end
      ST_PB0: begin
        if (hit) begin
          nxt = ST_FIN;
        end else if (lsb) begin
          cmd = CMD_SUB;
          nxt = ST_PB1;
        end
      end
      ST_PB1: begin
        if (hit) begin
          nxt = ST_FIN;
        end else if (!lsb) begin
          cmd = CMD_ADD;
          nxt = ST_PB0;
        end
      end
      default: begin
        nxt = ST_FIN;
      end
    endcase
  end
endmodule

// File: rtl/booth_state_reg.sv
`timescale 1ns/1ps
module booth_state_reg
  import booth_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrl_state_t d,
  output ctrl_state_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= ST_LOAD;
    else        q <= d;
  end
endmodule

// File: rtl/booth_seq_ctrl.sv
`timescale 1ns/1ps
module booth_seq_ctrl
  import booth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mplr_lsb,
  input  logic            count_hit,
  output logic [OP_W-1:0] op_code,
  output logic            finished
);
  logic        rst_q_n;
  ctrl_state_t st_cur;
  ctrl_state_t st_nxt;
  ctrl_cmd_t   cmd;

  booth_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // The raw reset also clears the state at once, so the outputs drop without a clock edge.
  logic st_rst_n;
  assign st_rst_n = rst_n & rst_q_n;

  booth_state_reg u_state (
    .clk   (clk),
    .rst_n (st_rst_n),
    .d     (st_nxt),
    .q     (st_cur)
  );

  booth_step_logic u_step (
    .cur (st_cur),
    .lsb (mplr_lsb),
    .hit (count_hit),
    .nxt (st_nxt),
    .cmd (cmd)
  );

  assign op_code  = cmd;
  assign finished = (st_cur == ST_FIN);
endmodule

module booth_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arst_n,
  input logic       mplr_lsb,
  input logic       count_hit,
  input logic [1:0] op_code,
  input logic       finished
);
  always_ff @(posedge clk) begin
    if (!arst_n) begin
      a_r1_reset_outputs: assert (op_code == 2'b00 && !finished);
    end
  end

  a_r2_load_once: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == 2'b00 |=> op_code != 2'b00);

  a_r4_sub_to_pb1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b10 && !count_hit) |=> (count_hit || mplr_lsb || op_code == 2'b01));

  a_r6_add_to_pb0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b01 && !count_hit) |=> (count_hit || !mplr_lsb || op_code == 2'b10));

  a_r7_shift_after_arith: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_code == 2'b01 || op_code == 2'b10) && !count_hit)
      |=> (!$stable(mplr_lsb) || count_hit || op_code == 2'b11));

  a_r8_hit_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hit && op_code != 2'b00 && !finished) |=> finished);

  a_r8_no_arith_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hit && op_code != 2'b00) |-> op_code == 2'b11);

  a_r9_finish_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> (finished && op_code == 2'b11));

  a_r10_finish_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 2'b11) |-> !finished);
endmodule

bind booth_seq_ctrl booth_seq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .arst_n    (rst_n),
  .mplr_lsb  (mplr_lsb),
  .count_hit (count_hit),
  .op_code   (op_code),
  .finished  (finished)
);

// File: tb/booth_seq_ctrl_test.sv
`timescale 1ns/1ps
module booth_seq_ctrl_test;
  localparam int N    = 8;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       mplr_lsb = 1'b0;
  logic       count_hit = 1'b0;
  logic [1:0] op_code;
  logic       finished;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  booth_seq_ctrl #(.SYNC_STAGES(SYNC)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mplr_lsb  (mplr_lsb),
    .count_hit (count_hit),
    .op_code   (op_code),
    .finished  (finished)
  );

  // model phase: 0 waiting for load, 1 prev bit 0, 2 prev bit 1, 3 finished
  int            mst;
  int            inits;
  int            cnt;
  logic          prev_arith;
  logic [2*N:0]  pair;
  logic [N-1:0]  mcand;
  logic [N-1:0]  mplier;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_cmd(int st, logic lsb, logic hit);
    if (st == 3 || hit) return 2'b11;
    if (st == 1) return lsb ? 2'b10 : 2'b11;
    return lsb ? 2'b11 : 2'b01;
  endfunction

  function automatic int exp_next(int st, logic lsb, logic hit);
    if (st == 3 || hit) return 3;
    return lsb ? 2 : 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(op_code == 2'b00 && !finished, "R11", {op_code, finished}, 0);
    repeat (2) @(negedge clk);
    chk(op_code == 2'b00 && !finished, "R1", {op_code, finished}, 0);
    rst_n = 1'b1;
    mst = 0;
    inits = 0;
    prev_arith = 1'b0;
  endtask

  task automatic step(input logic lsb, input logic hit);
    logic [1:0] e;
    string tag;
    @(negedge clk);
    mplr_lsb = lsb;
    count_hit = hit;
    #0.5;
    if (mst == 0) begin
      if (op_code == 2'b00) begin
        inits++;
        chk(inits <= SYNC + 1, "R2", inits, SYNC + 1);
        chk(!finished, "R10", finished, 0);
        pair = {{(N+1){1'b0}}, mplier};
        cnt = 0;
        return;
      end
      chk(inits >= 1, "R2", inits, 1);
      mst = 1;
    end
    e = exp_cmd(mst, lsb, hit);
    if (mst == 3)                             tag = "R9";
    else if (hit)                             tag = "R8";
    else if (prev_arith && e == 2'b11)        tag = "R7";
    else if (mst == 1)                        tag = lsb ? "R4" : "R3";
    else                                      tag = lsb ? "R5" : "R6";
    chk(op_code == e, tag, op_code, e);
    chk(finished == (mst == 3), "R10", finished, mst == 3);
    if ((mst == 1 || mst == 2) && !hit) begin
      case (op_code)
        2'b01: pair[2*N:N] = pair[2*N:N] + {mcand[N-1], mcand};
        2'b10: pair[2*N:N] = pair[2*N:N] - {mcand[N-1], mcand};
        2'b11: begin pair = {pair[2*N], pair[2*N:1]}; cnt++; end
        default: ;
      endcase
    end
    prev_arith = (op_code == 2'b01 || op_code == 2'b10);
    mst = exp_next(mst, lsb, hit);
  endtask

  task automatic run_mult(input logic [N-1:0] m, input logic [N-1:0] q);
    logic signed [2*N-1:0] want;
    mcand = m;
    mplier = q;
    cnt = N;
    do_reset();
    for (int i = 0; i < 4*N + 10 && mst != 3; i++) step(pair[0], cnt == N);
    chk(mst == 3, "R8", mst, 3);
    want = $signed(m) * $signed(q);
    chk(pair[2*N-1:0] == want, "R8", int'(pair[2*N-1:0]), int'(want));
    for (int k = 0; k < 3; k++) step(1'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_b007));
    #0.1 rst_n = 1'b0;

    // directed operand corners
    run_mult(8'h80, 8'h80);
    run_mult(8'hFF, 8'hFF);
    run_mult(8'h55, 8'hAA);
    run_mult(8'h00, 8'h7F);
    run_mult(8'h7F, 8'h01);

    // completion flag beats a pending add (R8)
    mplier = 8'h00;
    do_reset();
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    chk(mst == 3, "R8", mst, 3);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);

    // reset straight out of the finished state (R11)
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.2;
    chk(op_code == 2'b00 && !finished, "R11", {op_code, finished}, 0);

    // reset in the middle of a run
    mcand = 8'h3C;
    mplier = 8'h96;
    cnt = N;
    do_reset();
    for (int i = 0; i < 6; i++) step(pair[0], cnt == N);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.2;
    chk(op_code == 2'b00 && !finished, "R11", {op_code, finished}, 0);

    // random operands
    for (int t = 0; t < 40; t++) run_mult(N'($urandom), N'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule